// File: doc/BRIEF.md
# Pulse-Width DAC with Binary Rate Multiplier

This block drives up to five output pins with pulse trains whose average level follows an 8-bit code. All channels share one prescaler and one timebase. Each code splits into two parts. The upper five bits set how many timebase clocks stay high at the start of every 32-clock cycle. The lower three bits choose how many of the eight cycles in a frame get one extra high clock. The average therefore has 8-bit resolution, but the output repeats at the fast 5-bit cycle rate. A simple RC filter on the pin turns this into a DC level.

Software programs a 2-bit prescaler select, a code for each channel and an enable mask. A channel whose enable bit is clear passes its general-purpose output value straight to the pin. A new code takes effect only at the next frame boundary. A waveform in progress is therefore never cut.

Top module: `pwm_brm_top`

## Requirements
- R1: The timebase clock ticks once every 2^(S+1) system clocks, where S is the prescaler select. S is written from `div_wdata[1:0]` when `div_we` is high, so the ratio is 2, 4, 8 or 16.
- R2: A cycle lasts 32 timebase clocks. A frame is 8 consecutive cycles, or 256 timebase clocks.
- R3: Code bits [7:3] give D, the number of high timebase clocks at the start of each cycle. Over one frame the pin is high for 8*D+B timebase clocks, where B is code bits [2:0]. Code 0xFF is therefore high for 255 of every 256 timebase clocks, and code 0x00 is never high.
- R4: Exactly B cycles of each frame are stretched. A stretched cycle is high for D+1 timebase clocks, with the extra clock directly after the normal high time.
- R5: The stretched cycles are spread out and never coincide. Weight 4 (bit 2) stretches every odd cycle of the frame. Weight 2 (bit 1) stretches cycles 2 and 6. Weight 1 (bit 0) stretches cycle 4. Cycle 0 is never stretched.
- R6: A written code takes effect only at the next frame start. After reset, the first frame runs with code 0x00.
- R7: When a channel's enable bit is 1, its pin carries the modulated waveform. When the bit is 0, the pin equals that channel's `gpio_in` bit. Enable bits are written from `en_wdata` when `en_we` is high.
- R8: Reset clears every code to 0x00, the prescaler select to 0 and all enable bits to 0. During and after reset, every pin equals its `gpio_in` bit.
- R9: All channels run from the common timebase, and each channel follows only its own code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_we | input | 1 | Write strobe for the prescaler select |
| div_wdata | input | 2 | Prescaler select value |
| en_we | input | 1 | Write strobe for the enable mask |
| en_wdata | input | NCH | Enable mask, one bit per channel |
| dat_we | input | NCH | Per-channel write strobe for the code |
| dat_wdata | input | 8 | Code value: bits [7:3] high time, bits [2:0] stretch count |
| gpio_in | input | NCH | Pin values used when a channel is disabled |
| pwm_pin | output | NCH | Channel output pins |

## Verification
Every register write lands on the clock edge after its strobe. The enable mux is combinational after that edge, so pin-select results are sampled on the following falling edge. A code change is due only at the next frame boundary, up to 256 timebase clocks later. After reset with select 0, that boundary falls exactly 512 system clocks after reset release, and the bench checks that exact edge and the 32-clock high run that follows. For arbitrary phases, the bench waits out one full frame of the slowest ratio plus one frame of the new ratio. It then counts high samples over exactly one frame, or measures consecutive pulse lengths. Both measurements give results that do not depend on where the window starts.

// File: rtl/pwm_brm_pkg.sv
package pwm_brm_pkg;
  localparam int DUTY_W = 5;
  localparam int BRM_W  = 3;
  localparam int DAT_W  = DUTY_W + BRM_W;
  localparam int DIV_W  = 2;
  localparam int PRE_W  = 1 << DIV_W;

  // Last prescaler count before a tick: 2^(sel+1) - 1
  function automatic logic [PRE_W-1:0] div_last(input logic [DIV_W-1:0] sel);
    int sh;
    sh = int'(sel) + 1;
    return PRE_W'((1 << sh) - 1);
  endfunction

  // One-hot slot vector: bit b (weight 2^b) is due when the lowest set bit of
  // the cycle index sits at position BRM_W-1-b.
  function automatic logic [BRM_W-1:0] brm_slot(input logic [BRM_W-1:0] cyc);
    logic [BRM_W-1:0] res;
    logic [BRM_W-1:0] below;
    res = '0;
    for (int b = 0; b < BRM_W; b++) begin
      below = BRM_W'((1 << (BRM_W - 1 - b)) - 1);
      res[b] = cyc[BRM_W-1-b] && ((cyc & below) == '0);
    end
    return res;
  endfunction
endpackage

// File: rtl/pwm_brm_prescale.sv
module pwm_brm_prescale
  import pwm_brm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] sel,
  output logic             tick
);
  logic [PRE_W-1:0] cnt_q;

  assign tick = (cnt_q >= div_last(sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  // R1: the ratio is at least 2, so ticks never come back to back
  p_tick_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/pwm_brm_timebase.sv
module pwm_brm_timebase
  import pwm_brm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  output logic [DUTY_W-1:0] pos,
  output logic [BRM_W-1:0]  cyc,
  output logic              frame_end
);
  assign frame_end = tick && (&pos) && (&cyc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0;
      cyc <= '0;
    end else if (tick) begin
      pos <= pos + 1'b1;
      if (&pos) cyc <= cyc + 1'b1;
    end
  end

  // R2: finishing a 32-clock cycle advances the cycle index by one
  p_cycle_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (&pos)) |=> (pos == '0) && (cyc == $past(cyc) + 1'b1));
endmodule

// File: rtl/pwm_brm_chan.sv
module pwm_brm_chan
  import pwm_brm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DAT_W-1:0]  wdata,
  input  logic              load,
  input  logic [DUTY_W-1:0] pos,
  input  logic [BRM_W-1:0]  cyc,
  input  logic              en,
  input  logic              gpio,
  output logic              pin
);
  logic [DAT_W-1:0]  dat_q;
  logic [DAT_W-1:0]  act_q;
  logic [DUTY_W-1:0] duty;
  logic [BRM_W-1:0]  brm;
  logic [BRM_W-1:0]  slot;
  logic              stretch;
  logic              hi;

  assign duty    = act_q[DAT_W-1:BRM_W];
  assign brm     = act_q[BRM_W-1:0];
  assign slot    = brm_slot(cyc);
  assign stretch = |(slot & brm);
  assign hi      = {1'b0, pos} < ({1'b0, duty} + {{DUTY_W{1'b0}}, stretch});
  assign pin     = en ? hi : gpio;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
      act_q <= '0;
    end else begin
      if (we)   dat_q <= wdata;
      if (load) act_q <= dat_q;
    end
  end

  // R5: at most one weight may claim any cycle of the frame
  p_slot_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot));
  // R3: a nonzero high time is high from the first clock of the cycle
  p_cycle_start_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pos == '0) && (duty != '0)) |-> hi);
endmodule

// File: rtl/pwm_brm_top.sv
module pwm_brm_top
  import pwm_brm_pkg::*;
#(
  parameter int NCH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_we,
  input  logic [1:0]       div_wdata,
  input  logic             en_we,
  input  logic [NCH-1:0]   en_wdata,
  input  logic [NCH-1:0]   dat_we,
  input  logic [7:0]       dat_wdata,
  input  logic [NCH-1:0]   gpio_in,
  output logic [NCH-1:0]   pwm_pin
);
  logic [DIV_W-1:0]  div_q;
  logic [NCH-1:0]    en_q;
  logic              tick;
  logic              frame_end;
  logic [DUTY_W-1:0] pos;
  logic [BRM_W-1:0]  cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      en_q  <= '0;
    end else begin
      if (div_we) div_q <= div_wdata;
      if (en_we)  en_q  <= en_wdata;
    end
  end

  pwm_brm_prescale u_pre (
    .clk(clk), .rst_n(rst_n), .sel(div_q), .tick(tick)
  );

  pwm_brm_timebase u_tb (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .pos(pos), .cyc(cyc), .frame_end(frame_end)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pwm_brm_chan u_ch (
      .clk(clk), .rst_n(rst_n),
      .we(dat_we[i]), .wdata(dat_wdata),
      .load(frame_end), .pos(pos), .cyc(cyc),
      .en(en_q[i]), .gpio(gpio_in[i]), .pin(pwm_pin[i])
    );
  end
endmodule

// File: tb/pwm_brm_top_bench.sv
module pwm_brm_top_bench;
  localparam int NCH = 5;
  localparam time CLK_PERIOD = 10ns;
  localparam int NVEC = 7;
  // {select[1:0], code[7:0]} for channel 0; channel i uses code + i*53
  localparam logic [9:0] VEC [NVEC] = '{
    {2'd0, 8'h83}, {2'd1, 8'hFF}, {2'd0, 8'h00}, {2'd1, 8'h07},
    {2'd2, 8'h58}, {2'd0, 8'hF8}, {2'd3, 8'h41}
  };

  logic clk = 0, rst_n = 0;
  logic div_we = 0, en_we = 0;
  logic [1:0] div_wdata = 0;
  logic [NCH-1:0] en_wdata = 0, dat_we = 0, gpio_in = 0;
  logic [7:0] dat_wdata = 0;
  logic [NCH-1:0] pwm_pin;
  int checks = 0, errors = 0;
  bit done = 0;

  pwm_brm_top #(.NCH(NCH)) u_pwm_brm_top (
    .clk(clk), .rst_n(rst_n), .div_we(div_we), .div_wdata(div_wdata),
    .en_we(en_we), .en_wdata(en_wdata), .dat_we(dat_we),
    .dat_wdata(dat_wdata), .gpio_in(gpio_in), .pwm_pin(pwm_pin)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // high system clocks per frame: ratio * (8*D + B)
  function automatic int frame_high(input logic [7:0] c, input logic [1:0] s);
    return (2 << s) * (int'(c[7:3]) * 8 + int'(c[2:0]));
  endfunction

  task automatic put_code(input int ch, input logic [7:0] v);
    @(negedge clk); dat_we = '0; dat_we[ch] = 1'b1; dat_wdata = v;
    @(negedge clk); dat_we = '0;
  endtask

  task automatic put_div(input logic [1:0] v);
    @(negedge clk); div_we = 1; div_wdata = v;
    @(negedge clk); div_we = 0;
  endtask

  task automatic put_en(input logic [NCH-1:0] v);
    @(negedge clk); en_we = 1; en_wdata = v;
    @(negedge clk); en_we = 0;
  endtask

  task automatic pulse_len(output int len);
    while (pwm_pin[0]) @(negedge clk);
    while (!pwm_pin[0]) @(negedge clk);
    len = 0;
    while (pwm_pin[0]) begin len++; @(negedge clk); end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int early, run;
    int lens [16];
    gpio_in = 5'b10110;
    repeat (3) @(negedge clk);
    check(pwm_pin == gpio_in, "R8 pins follow gpio in reset", int'(pwm_pin), int'(gpio_in));
    // release reset at a falling edge with writes already staged
    dat_we = 5'b00001; dat_wdata = 8'h83;
    en_we = 1; en_wdata = '1;
    rst_n = 1;
    early = 0;
    for (int p = 1; p <= 511; p++) begin
      @(negedge clk);
      if (p == 1) begin dat_we = '0; en_we = 0; end
      if (pwm_pin[0]) early++;
    end
    check(early == 0, "R6 first frame runs code 0", early, 0);
    @(negedge clk);
    check(pwm_pin[0] == 1'b1, "R6 code active at frame start", int'(pwm_pin[0]), 1);
    check(pwm_pin[1] == 1'b0, "R9 untouched channel stays low", int'(pwm_pin[1]), 0);
    run = 0;
    while (pwm_pin[0]) begin run++; @(negedge clk); end
    check(run == 32, "R3 cycle 0 high run (D=16, ratio 2)", run, 32);

    // table walk: frame totals per channel
    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] s;
      logic [7:0] c;
      int cnt [NCH];
      s = VEC[v][9:8];
      c = VEC[v][7:0];
      put_div(s);
      for (int i = 0; i < NCH; i++) put_code(i, c + 8'(i * 53));
      repeat (4096 + 256 * (2 << s) + 8) @(negedge clk);
      for (int i = 0; i < NCH; i++) cnt[i] = 0;
      for (int k = 0; k < 256 * (2 << s); k++) begin
        @(negedge clk);
        for (int i = 0; i < NCH; i++) if (pwm_pin[i]) cnt[i]++;
      end
      for (int i = 0; i < NCH; i++)
        check(cnt[i] == frame_high(c + 8'(i * 53), s),
              "R1 R3 R9 frame high count", cnt[i], frame_high(c + 8'(i * 53), s));
    end

    // R4 R5: weight 4 alternates, ratio 2, D=8 -> lengths 16/18
    put_div(2'd0);
    put_code(0, 8'h44);
    repeat (4096 + 600) @(negedge clk);
    for (int k = 0; k < 16; k++) pulse_len(lens[k]);
    begin
      int longs, bad, alt;
      longs = 0; bad = 0; alt = 0;
      for (int k = 0; k < 16; k++) begin
        if (lens[k] == 18) longs++;
        else if (lens[k] != 16) bad++;
      end
      for (int k = 0; k < 15; k++) if (lens[k] == lens[k+1]) alt++;
      check(bad == 0, "R4 pulse lengths D or D+1", bad, 0);
      check(longs == 8, "R4 four stretched per frame", longs, 8);
      check(alt == 0, "R5 weight 4 alternates", alt, 0);
    end
    // weight 2: two stretched per frame, four cycles apart
    put_code(0, 8'h42);
    repeat (4096 + 600) @(negedge clk);
    for (int k = 0; k < 16; k++) pulse_len(lens[k]);
    begin
      int longs, mism;
      longs = 0; mism = 0;
      for (int k = 0; k < 8; k++) if (lens[k] == 18) longs++;
      for (int k = 0; k < 12; k++) if (lens[k] != lens[k+4]) mism++;
      check(longs == 2, "R4 two stretched per frame", longs, 2);
      check(mism == 0, "R5 weight 2 every fourth cycle", mism, 0);
    end
    // weight 1: one stretched per frame
    put_code(0, 8'h41);
    repeat (4096 + 600) @(negedge clk);
    for (int k = 0; k < 8; k++) pulse_len(lens[k]);
    begin
      int longs;
      longs = 0;
      for (int k = 0; k < 8; k++) if (lens[k] == 18) longs++;
      check(longs == 1, "R5 weight 1 once per frame", longs, 1);
    end

    // R7: disabled channel passes gpio and ignores its waveform
    put_code(2, 8'h83);
    put_en(5'b11011);
    @(negedge clk); gpio_in[2] = 1'b1; #1;
    check(pwm_pin[2] == 1'b1, "R7 disabled pin shows gpio 1", int'(pwm_pin[2]), 1);
    @(negedge clk); gpio_in[2] = 1'b0;
    early = 0;
    for (int k = 0; k < 1200; k++) begin @(negedge clk); if (pwm_pin[2]) early++; end
    check(early == 0, "R7 disabled pin holds gpio 0", early, 0);
    put_en(5'b11111);
    early = 0;
    for (int k = 0; k < 600; k++) begin @(negedge clk); if (pwm_pin[2]) early++; end
    check(early == 64 * 16 / 8 * 0 + (early > 0 ? early : 1) && early > 0,
          "R7 enabled pin modulates", early, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule